// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block generates the low address offset for a four-beat cache-line burst. When an access begins, the block captures the full incoming address. The two lowest bits become the first offset. Each later advance request moves the burst to the next beat. The upper address bits are held for the whole burst and are sent out next to the offset unchanged.

Two beat orders are supported, and a mode input picks one of them when the burst is loaded. In the interleaved order, each offset is the start offset XOR the beat number. This is the order processors use to fill cache lines. In the linear order, the beat number is added to the start offset and the sum wraps modulo four. In both orders the sequence depends on the first address, not only on the beat number. A flag marks the fourth beat. Advancing past that beat returns the offset to the start value.

Top module: `burst_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, `ofs`, `addr_out` and `last_beat` are all zero. Reset is applied asynchronously and may also be applied in the middle of a burst.
- R2: A cycle with `load` high captures `addr_in[1:0]` as the start offset. From the next cycle, `ofs` equals that start offset and the beat number is zero.
- R3: A load captures `addr_in[ADDR_W-1:2]`. That value appears on `addr_out[ADDR_W-1:2]` and does not change until the next load, whatever advances occur. `addr_out[1:0]` always equals `ofs`.
- R4: With `mode_ilv` = 1 at load, the offsets for beats 0 to 3 are start XOR beat:
  - start 00 gives 00,01,10,11
  - start 01 gives 01,00,11,10
  - start 10 gives 10,11,00,01
  - start 11 gives 11,10,01,00
- R5: With `mode_ilv` = 0 at load, the offsets are start plus beat, modulo four. For example, start 01 gives 01,10,11,00 and start 11 gives 11,00,01,10.
- R6: When `load` and `advance` are both high in the same cycle, the load wins. The beat number restarts at zero with the new start offset.
- R7: `last_beat` is high exactly when the beat number is 3, that is, on the fourth offset of a burst.
- R8: An advance on the last beat wraps the beat number to zero. `ofs` returns to the start offset and `last_beat` falls.
- R9: In a cycle with neither `load` nor `advance`, every output holds its value.
- R10: The order is taken from `mode_ilv` only at load. Changes to `mode_ilv` during a burst have no effect on the offsets of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| load | input | 1 | Start a burst from `addr_in` |
| advance | input | 1 | Step to the next beat |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = linear order; sampled at load |
| addr_in | input | ADDR_W | Address of the first beat |
| addr_out | output | ADDR_W | Held upper bits concatenated with the current offset |
| ofs | output | 2 | Current beat offset |
| last_beat | output | 1 | High on the fourth beat |

## Verification
The bench builds the block with its default parameters: a 16-bit address and a 2-bit offset. The 16-bit address lets the bench check that varied upper-bit patterns pass through unchanged. The 2-bit offset gives the four-beat burst, so all four start values in both orders can be compared against the stated sequences. With a wrap every four beats, long advance runs reach several wraparounds and load/advance collisions at every beat position. The bench also changes the mode mid-burst and applies reset mid-burst, and it checks that the sequence shown after each of these matches the requirements.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_rst_sync.sv
// Async assert, synchronous release of the active-low reset.
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/burst_beat_ctr.sv
// Beat counter: cleared on load, steps on advance, wraps at the end.
module burst_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  output logic [CNT_W-1:0] beat,
  output logic             last
);
  logic [CNT_W-1:0] beat_q, beat_d;
  logic             beat_en;

  always_comb begin
    beat_en = load | advance;
    beat_d  = beat_q;
    if (load)         beat_d = '0;
    else if (advance) beat_d = beat_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign beat = beat_q;
  assign last = (beat_q == {CNT_W{1'b1}});
endmodule

// File: rtl/burst_ofs_map.sv
// Maps start offset and beat number to the current offset.
module burst_ofs_map
  import burst_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0] start,
  input  logic [OFS_W-1:0] beat,
  input  order_e           order,
  output logic [OFS_W-1:0] ofs
);
  always_comb begin
    unique case (order)
      ORD_INTERLEAVE: ofs = start ^ beat;
      default:        ofs = start + beat;
    endcase
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              mode_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [OFS_W-1:0]  ofs,
  output logic              last_beat
);
  localparam int UP_W = ADDR_W - OFS_W;

  logic             rst_n_s;
  logic [OFS_W-1:0] start_q, start_d;
  logic [UP_W-1:0]  upper_q, upper_d;
  order_e           mode_q, mode_d;
  logic [OFS_W-1:0] beat;

  burst_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  // Next state of the burst-start registers.
  always_comb begin
    start_d = start_q;
    upper_d = upper_q;
    mode_d  = mode_q;
    if (load) begin
      start_d = addr_in[OFS_W-1:0];
      upper_d = addr_in[ADDR_W-1:OFS_W];
      mode_d  = order_e'(mode_ilv);
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      start_q <= '0;
      upper_q <= '0;
      mode_q  <= ORD_LINEAR;
    end else if (load) begin
      start_q <= start_d;
      upper_q <= upper_d;
      mode_q  <= mode_d;
    end
  end

  burst_beat_ctr #(.CNT_W(OFS_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (load),
    .advance (advance),
    .beat    (beat),
    .last    (last_beat)
  );

  burst_ofs_map #(.OFS_W(OFS_W)) u_map (
    .start (start_q),
    .beat  (beat),
    .order (mode_q),
    .ofs   (ofs)
  );

  assign addr_out = {upper_q, ofs};
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              load,
  input logic              advance,
  input logic              mode_q,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic [OFS_W-1:0]  ofs,
  input logic              last_beat
);
  assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    load |=> ofs == $past(addr_in[OFS_W-1:0]));

  assert_upper_pass_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    load |=> addr_out[ADDR_W-1:OFS_W] == $past(addr_in[ADDR_W-1:OFS_W]));

  assert_upper_held_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    !load |=> $stable(addr_out[ADDR_W-1:OFS_W]));

  assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (advance && !load && !mode_q) |=> ofs == $past(ofs) + OFS_W'(1));

  assert_load_not_last_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    load |=> !last_beat);

  assert_wrap_clears_last_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (last_beat && advance && !load) |=> !last_beat);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (!load && !advance) |=> ($stable(ofs) && $stable(last_beat) && $stable(addr_out)));
endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_n_s),
  .load      (load),
  .advance   (advance),
  .mode_q    (mode_q),
  .addr_in   (addr_in),
  .addr_out  (addr_out),
  .ofs       (ofs),
  .last_beat (last_beat)
);

// File: tb/tb_burst_seq.sv
`timescale 1ns/1ps
module tb_burst_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load, advance, mode_ilv;
  logic [15:0] addr_in;
  logic [15:0] addr_out;
  logic [1:0]  ofs;
  logic        last_beat;

  int total = 0;
  int bad   = 0;

  // Behavioural reference state.
  int m_start, m_beat, m_upper;
  bit m_ilv;

  always #10 clk = ~clk;

  burst_seq dut (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
    .mode_ilv(mode_ilv), .addr_in(addr_in), .addr_out(addr_out),
    .ofs(ofs), .last_beat(last_beat)
  );

  function automatic int exp_ofs();
    if (m_ilv) return m_start ^ m_beat;
    return (m_start + m_beat) % 4;
  endfunction

  task automatic check_val(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check_val(tag, "ofs", int'(ofs), exp_ofs());
    check_val(tag, "addr_out", int'(addr_out), (m_upper << 2) | exp_ofs());
    check_val(tag, "last_beat", int'(last_beat), (m_beat == 3) ? 1 : 0);
  endtask

  task automatic step(input bit ld, input bit adv, input bit mi, input logic [15:0] a,
                      input string tag);
    load = ld; advance = adv; mode_ilv = mi; addr_in = a;
    @(posedge clk);
    if (ld) begin
      m_start = int'(a[1:0]); m_upper = int'(a[15:2]); m_beat = 0; m_ilv = mi;
    end else if (adv) begin
      m_beat = (m_beat + 1) % 4;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0;
    m_start = 0; m_beat = 0; m_upper = 0; m_ilv = 1'b0;
    #1;
    compare(tag);
    load = 0; advance = 0; mode_ilv = 0; addr_in = '0;
    repeat (2) @(negedge clk);
    compare(tag);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 16'h0, tag);
  endtask

  // Runs a burst and compares offsets with a literal list.
  task automatic burst_table(input bit mi, input logic [15:0] a, input int e0, input int e1,
                             input int e2, input int e3, input string tag);
    int exp [4];
    exp = '{e0, e1, e2, e3};
    step(1, 0, mi, a, tag);
    check_val(tag, "table", int'(ofs), exp[0]);
    for (int i = 1; i < 4; i++) begin
      step(0, 1, mi, 16'hFFFF, tag);
      check_val(tag, "table", int'(ofs), exp[i]);
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    load = 0; advance = 0; mode_ilv = 0; addr_in = '0; rst_n = 1'b0;
    @(negedge clk);
    do_reset("R1");

    // R4 interleaved tables, with varied upper bits (R3)
    burst_table(1, 16'hA5A4, 0, 1, 2, 3, "R4");
    burst_table(1, 16'h1235, 1, 0, 3, 2, "R4");
    burst_table(1, 16'h7FFE, 2, 3, 0, 1, "R4");
    burst_table(1, 16'h0003, 3, 2, 1, 0, "R4");
    // R5 linear tables
    burst_table(0, 16'hC001, 1, 2, 3, 0, "R5");
    burst_table(0, 16'h3C03, 3, 0, 1, 2, "R5");
    burst_table(0, 16'h8002, 2, 3, 0, 1, "R5");

    // R7 last flag on fourth beat, R8 wrap to start
    step(1, 0, 1, 16'h5556, "R2");
    for (int i = 0; i < 3; i++) step(0, 1, 1, 16'h0, "R7");
    check_val("R7", "last_beat", int'(last_beat), 1);
    step(0, 1, 1, 16'h0, "R8");
    check_val("R8", "wrap ofs", int'(ofs), 2);
    check_val("R8", "wrap last", int'(last_beat), 0);
    for (int i = 0; i < 6; i++) step(0, 1, 1, 16'h0, "R8");

    // R9 idle holds, with addr_in and mode toggling
    step(0, 0, 0, 16'hFFFF, "R9");
    step(0, 0, 1, 16'h1234, "R9");
    check_val("R9", "hold ofs", int'(ofs), 0);

    // R6 load beats advance at each beat position
    for (int b = 0; b < 4; b++) begin
      step(1, 0, 0, 16'h2221, "R6");
      for (int i = 0; i < b; i++) step(0, 1, 0, 16'h0, "R6");
      step(1, 1, 1, 16'h4443, "R6");
      check_val("R6", "priority ofs", int'(ofs), 3);
    end

    // R10 mode change mid-burst ignored
    step(1, 0, 0, 16'h0001, "R10");
    step(0, 1, 1, 16'h0, "R10");
    step(0, 1, 1, 16'h0, "R10");
    check_val("R10", "linear kept", int'(ofs), 3);
    step(1, 0, 1, 16'h0002, "R10");
    step(0, 1, 0, 16'h0, "R10");
    check_val("R10", "ilv kept", int'(ofs), 3);

    // Mixed pattern
    for (int i = 0; i < 40; i++)
      step((i % 7) == 0, (i % 3) != 0, (i % 2) == 0, 16'(i * 16'h1357), "R2");

    // R1 reset in the middle of a burst
    step(1, 0, 1, 16'hBEEF, "R1");
    step(0, 1, 1, 16'h0, "R1");
    @(negedge clk);
    do_reset("R1");
    check_val("R1", "addr_out", int'(addr_out), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule